// File: doc/BRIEF.md
# Queue-Driven Cluster Switching Controller

This controller decides which of two processor clusters executes the packet workload. Cluster 0 is the fast, power-hungry cluster. Cluster 1 is the slow, frugal cluster. The controller compares the occupancy of the incoming packet FIFO against two thresholds that software can program. While the queue stays shallow, the work moves to the slow cluster. When the queue backs up, the work moves to the fast cluster.

A handoff has three phases. In the run phase the active cluster fetches work normally. In the drain phase fetch is stalled, and in-flight instructions, including any pipeline recovery, are allowed to finish. During this phase the incoming cluster is woken early so that its startup latency is hidden. The swap phase lasts a single cycle: it enables the incoming cluster and shuts down the outgoing one. Fetch then resumes on the new cluster.

A read of an empty queue is not a switching trigger. It only produces an empty-packet indication, and the reader discards that indication. A saturating counter exposes how many handoffs have completed.

Top module: `clu_swap_ctrl`

## Requirements
- R1: After reset the controller is in the run phase (`ctrl_state` = 0). Cluster 0 is active (`active_clu` = 0 and `clu_enable` = 2'b01), `fetch_stall` is low and `switch_count` is 0.
- R2: In the run phase with cluster 0 active, an occupancy `o` with 0 < `o` <= `low_th` moves the controller to the drain phase (`ctrl_state` = 1) at the next clock, targeting cluster 1.
- R3: In the run phase with cluster 1 active, `o` >= `high_th` moves the controller to the drain phase targeting cluster 0. A high event while cluster 0 is active, or a low event while cluster 1 is active, has no effect.
- R4: An occupancy of 0 never starts a handoff.
- R5: In the drain phase `fetch_stall` is high and `clu_wake` has only the target cluster's bit set. In the run phase `clu_wake` is 0.
- R6: The drain phase ends only in a cycle where `pipe_empty[active_clu]` is high and `recov_busy` is low. While recovery is busy, the controller stays in the drain phase even if the pipeline is empty.
- R7: The swap phase (`ctrl_state` = 2) lasts exactly one cycle. During it, `clu_enable` has only the target bit set and `clu_shutdown` has the outgoing cluster's bit set. Next comes the run phase with `active_clu` equal to the target and `fetch_stall` low.
- R8: Exactly one bit of `clu_enable` is set in every cycle. `clu_shutdown` is set for each cluster that is neither enabled nor woken.
- R9: Occupancy and threshold changes during the drain or swap phase are ignored: the target does not change.
- R10: `switch_count` increases by one for each completed swap phase and saturates at its maximum value.
- R11: `empty_drop` is high in a cycle exactly when the controller is in the run phase, `rd_req` is high and occupancy is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| occupancy | input | OCC_W | Packet FIFO fill level, 0 to QDEPTH |
| low_th | input | OCC_W | Low-occupancy threshold |
| high_th | input | OCC_W | High-occupancy threshold |
| rd_req | input | 1 | Active cluster reads a packet |
| pipe_empty | input | 2 | Per-cluster pipeline-empty flag |
| recov_busy | input | 1 | Active pipeline is in error recovery |
| clu_enable | output | 2 | Per-cluster run enable |
| clu_wake | output | 2 | Early wake for the incoming cluster |
| clu_shutdown | output | 2 | Per-cluster shutdown request |
| fetch_stall | output | 1 | Instruction fetch halt |
| empty_drop | output | 1 | Empty-packet indication, discarded |
| active_clu | output | 1 | Index of the active cluster |
| ctrl_state | output | 2 | 0 run, 1 drain, 2 swap |
| switch_count | output | CNT_W | Saturating count of completed swaps |

## Verification
The assertions assume that `low_th` is strictly below `high_th`, that occupancy never exceeds the queue depth, and that `pipe_empty` and `recov_busy` describe the active cluster only during the drain phase. The random stimulus keeps the thresholds ordered whenever it changes them. It draws occupancy from a zero bucket, a below-low bucket, an above-high bucket and a middle bucket, all within the queue depth. The pipeline and recovery flags toggle freely, so that drains of several lengths occur.

// File: rtl/clu_pkg.sv
package clu_pkg;

  typedef enum logic [1:0] {
    ST_RUN   = 2'd0,
    ST_DRAIN = 2'd1,
    ST_SWAP  = 2'd2
  } clu_state_e;

  localparam logic CL_FAST = 1'b0;
  localparam logic CL_SLOW = 1'b1;

  // Shallow queue: worth moving to the frugal cluster (never on empty).
  function automatic logic shallow_evt(input int unsigned occ, input int unsigned lo);
    return (occ != 0) && (occ <= lo);
  endfunction

  // Deep queue: worth moving to the fast cluster.
  function automatic logic deep_evt(input int unsigned occ, input int unsigned hi);
    return occ >= hi;
  endfunction

  function automatic logic [1:0] sel2(input logic idx);
    return idx ? 2'b10 : 2'b01;
  endfunction

endpackage

// File: rtl/clu_thresh.sv
module clu_thresh
  import clu_pkg::*;
#(
  parameter int OCC_W = 10
) (
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] low_th,
  input  logic [OCC_W-1:0] high_th,
  input  logic             cur,
  output logic             swap_req
);

  logic shallow, deep;

  always_comb begin
    shallow  = shallow_evt(32'(occupancy), 32'(low_th));
    deep     = deep_evt(32'(occupancy), 32'(high_th));
    // Only the event that points away from the current cluster counts.
    swap_req = (cur == CL_FAST) ? shallow : deep;
  end

  always_comb begin
    if (occupancy == '0) assert_no_req_on_empty_R4: assert (!swap_req || cur == CL_SLOW);
  end

endmodule

// File: rtl/clu_fsm.sv
module clu_fsm
  import clu_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             swap_req,
  input  logic [1:0]       pipe_empty,
  input  logic             recov_busy,
  output clu_state_e       state,
  output logic             cur,
  output logic             tgt,
  output logic             drain_done,
  output logic [CNT_W-1:0] switch_count
);

  localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

  clu_state_e state_nx;

  always_comb begin
    drain_done = (state == ST_DRAIN) && pipe_empty[cur] && !recov_busy;
    state_nx   = state;
    unique case (state)
      ST_RUN:   if (swap_req) state_nx = ST_DRAIN;
      ST_DRAIN: if (drain_done) state_nx = ST_SWAP;
      ST_SWAP:  state_nx = ST_RUN;
      default:  state_nx = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state        <= ST_RUN;
      cur          <= CL_FAST;
      tgt          <= CL_SLOW;
      switch_count <= '0;
    end else begin
      state <= state_nx;
      if (state == ST_RUN && swap_req) tgt <= ~cur;
      if (state == ST_SWAP) begin
        cur <= tgt;
        if (switch_count != CNT_MAX) switch_count <= switch_count + 1'b1;
      end
    end
  end

  assert_swap_one_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_SWAP |=> state == ST_RUN && cur == $past(tgt));

  assert_recovery_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DRAIN && recov_busy) |=> state == ST_DRAIN);

  assert_target_frozen_R9: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_RUN |=> $stable(tgt));

  assert_count_step_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_SWAP && switch_count != CNT_MAX) |=> switch_count == $past(switch_count) + 1'b1);

  assert_count_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    state != ST_SWAP |=> $stable(switch_count));

endmodule

// File: rtl/clu_outdec.sv
module clu_outdec
  import clu_pkg::*;
(
  input  clu_state_e  state,
  input  logic        cur,
  input  logic        tgt,
  input  logic        occ_zero,
  input  logic        rd_req,
  output logic [1:0]  clu_enable,
  output logic [1:0]  clu_wake,
  output logic [1:0]  clu_shutdown,
  output logic        fetch_stall,
  output logic        empty_drop
);

  always_comb begin
    clu_enable   = (state == ST_SWAP) ? sel2(tgt) : sel2(cur);
    clu_wake     = (state == ST_DRAIN) ? sel2(tgt) : 2'b00;
    clu_shutdown = ~(clu_enable | clu_wake);
    fetch_stall  = (state != ST_RUN);
    empty_drop   = (state == ST_RUN) && rd_req && occ_zero;
  end

  always_comb begin
    assert_single_enable_R8: assert ($countones(clu_enable) == 1);
    if (state == ST_DRAIN) assert_drain_outputs_R5: assert (fetch_stall && clu_wake[tgt] && !clu_wake[cur]);
    if (state == ST_SWAP) assert_old_shut_R7: assert (clu_shutdown[cur] && clu_enable[tgt]);
  end

endmodule

// File: rtl/clu_swap_ctrl.sv
module clu_swap_ctrl
  import clu_pkg::*;
#(
  parameter int QDEPTH = 512,
  parameter int CNT_W  = 8,
  localparam int OCC_W = $clog2(QDEPTH + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [OCC_W-1:0] occupancy,
  input  logic [OCC_W-1:0] low_th,
  input  logic [OCC_W-1:0] high_th,
  input  logic             rd_req,
  input  logic [1:0]       pipe_empty,
  input  logic             recov_busy,
  output logic [1:0]       clu_enable,
  output logic [1:0]       clu_wake,
  output logic [1:0]       clu_shutdown,
  output logic             fetch_stall,
  output logic             empty_drop,
  output logic             active_clu,
  output logic [1:0]       ctrl_state,
  output logic [CNT_W-1:0] switch_count
);

  clu_state_e st;
  logic       cur, tgt, swap_req, drain_done, occ_zero;

  assign occ_zero   = (occupancy == '0);
  assign active_clu = cur;
  assign ctrl_state = st;

  clu_thresh #(.OCC_W(OCC_W)) u_thresh (
    .occupancy (occupancy),
    .low_th    (low_th),
    .high_th   (high_th),
    .cur       (cur),
    .swap_req  (swap_req)
  );

  clu_fsm #(.CNT_W(CNT_W)) u_fsm (
    .clk          (clk),
    .rst_n        (rst_n),
    .swap_req     (swap_req),
    .pipe_empty   (pipe_empty),
    .recov_busy   (recov_busy),
    .state        (st),
    .cur          (cur),
    .tgt          (tgt),
    .drain_done   (drain_done),
    .switch_count (switch_count)
  );

  clu_outdec u_dec (
    .state        (st),
    .cur          (cur),
    .tgt          (tgt),
    .occ_zero     (occ_zero),
    .rd_req       (rd_req),
    .clu_enable   (clu_enable),
    .clu_wake     (clu_wake),
    .clu_shutdown (clu_shutdown),
    .fetch_stall  (fetch_stall),
    .empty_drop   (empty_drop)
  );

  assert_empty_no_switch_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && occ_zero) |=> st == ST_RUN);

  assert_drain_needs_empty_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_DRAIN && !drain_done) |=> st == ST_DRAIN);

  assert_wrong_way_ignored_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == ST_RUN && cur == CL_FAST && occupancy >= high_th && occupancy > low_th) |=> st == ST_RUN);

endmodule

// File: tb/clu_swap_ctrl_test.sv
module clu_swap_ctrl_test;

  localparam int QDEPTH = 512;
  localparam int CNT_W  = 4;
  localparam int OCC_W  = $clog2(QDEPTH + 1);
  localparam int CMAX   = (1 << CNT_W) - 1;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [OCC_W-1:0] occupancy = '0, low_th = 10'd100, high_th = 10'd400;
  logic rd_req = 1'b0, recov_busy = 1'b0;
  logic [1:0] pipe_empty = 2'b00;
  logic [1:0] clu_enable, clu_wake, clu_shutdown, ctrl_state;
  logic fetch_stall, empty_drop, active_clu;
  logic [CNT_W-1:0] switch_count;

  int tests = 0, fails = 0;
  bit done = 0;

  // reference model
  int m_state = 0, m_cnt = 0;
  logic m_cur = 1'b0, m_tgt = 1'b1;

  always #4 clk = ~clk;

  clu_swap_ctrl #(.QDEPTH(QDEPTH), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst_n(rst_n), .occupancy(occupancy), .low_th(low_th), .high_th(high_th),
    .rd_req(rd_req), .pipe_empty(pipe_empty), .recov_busy(recov_busy),
    .clu_enable(clu_enable), .clu_wake(clu_wake), .clu_shutdown(clu_shutdown),
    .fetch_stall(fetch_stall), .empty_drop(empty_drop), .active_clu(active_clu),
    .ctrl_state(ctrl_state), .switch_count(switch_count));

  function automatic logic [1:0] bit_of(input logic i);
    return i ? 2'b10 : 2'b01;
  endfunction

  function automatic bit ref_event(input logic cur, input int occ, input int lo, input int hi);
    if (cur == 1'b0) return (occ > 0) && (occ <= lo);
    return occ >= hi;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_edge();
    if (!rst_n) begin
      m_state = 0; m_cur = 1'b0; m_tgt = 1'b1; m_cnt = 0;
    end else begin
      case (m_state)
        0: if (ref_event(m_cur, int'(occupancy), int'(low_th), int'(high_th))) begin
             m_state = 1; m_tgt = ~m_cur;
           end
        1: if (pipe_empty[m_cur] && !recov_busy) m_state = 2;
        default: begin
          m_cur = m_tgt; m_state = 0;
          if (m_cnt != CMAX) m_cnt++;
        end
      endcase
    end
  endtask

  task automatic compare_all();
    logic [1:0] en_e, wk_e;
    en_e = (m_state == 2) ? bit_of(m_tgt) : bit_of(m_cur);
    wk_e = (m_state == 1) ? bit_of(m_tgt) : 2'b00;
    chk("R2 state", int'(ctrl_state), m_state);
    chk("R7 active cluster", int'(active_clu), int'(m_cur));
    chk("R8 enable", int'(clu_enable), int'(en_e));
    chk("R5 wake", int'(clu_wake), int'(wk_e));
    chk("R8 shutdown", int'(clu_shutdown), int'(~(en_e | wk_e) & 2'b11));
    chk("R5 fetch stall", int'(fetch_stall), int'(m_state != 0));
    chk("R10 count", int'(switch_count), m_cnt);
    chk("R11 empty drop", int'(empty_drop), int'(m_state == 0 && rd_req && occupancy == 0));
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    compare_all();
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      done = 1; fails++; tests++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    step(); step();
    @(negedge clk) rst_n = 1'b1;
    // R1 reset state
    chk("R1 state", int'(ctrl_state), 0);
    chk("R1 active", int'(active_clu), 0);
    chk("R1 enable", int'(clu_enable), 1);
    chk("R1 stall", int'(fetch_stall), 0);
    chk("R1 count", int'(switch_count), 0);

    // R4 and R11: empty queue, fast cluster active, no switch
    occupancy = 0; rd_req = 1'b1;
    repeat (4) step();
    chk("R4 empty stays running", int'(ctrl_state), 0);
    chk("R11 drop seen", int'(empty_drop), 1);
    rd_req = 1'b0;

    // R3: deep queue with fast active is ignored
    occupancy = 450; step(); step();
    chk("R3 high ignored on fast", int'(ctrl_state), 0);

    // R2: shallow queue starts drain to slow
    occupancy = 50; step();
    chk("R2 drain entered", int'(ctrl_state), 1);
    chk("R5 wake slow", int'(clu_wake), 2);

    // R6 + R9: recovery busy holds drain; threshold change ignored
    recov_busy = 1'b1; pipe_empty = 2'b11; occupancy = 500; low_th = 5; high_th = 20;
    repeat (3) step();
    chk("R6 drain held", int'(ctrl_state), 1);
    chk("R9 target kept", int'(clu_wake), 2);
    recov_busy = 1'b0; low_th = 100; high_th = 400; step();
    chk("R7 swap enable", int'(clu_enable), 2);
    chk("R7 swap shutdown", int'(clu_shutdown), 1);
    occupancy = 200; step();
    chk("R7 back running", int'(ctrl_state), 0);
    chk("R7 slow active", int'(active_clu), 1);

    // R3: shallow ignored with slow active, deep returns to fast
    occupancy = 30; step(); step();
    chk("R3 low ignored on slow", int'(ctrl_state), 0);
    occupancy = 420; pipe_empty = 2'b00; step();
    chk("R3 drain to fast", int'(clu_wake), 1);
    repeat (3) step();
    chk("R6 waits pipe empty", int'(ctrl_state), 1);
    pipe_empty = 2'b10; step(); step();
    chk("R7 fast active", int'(active_clu), 0);

    // random phase, also drives the counter into saturation (R10)
    for (int i = 0; i < 4000; i++) begin
      int b;
      b = int'($urandom % 4);
      case (b)
        0: occupancy = 0;
        1: occupancy = OCC_W'(1 + ($urandom % int'(low_th)));
        2: occupancy = OCC_W'(int'(high_th) + ($urandom % (QDEPTH + 1 - int'(high_th))));
        default: occupancy = OCC_W'(int'(low_th) + 1 + ($urandom % (int'(high_th) - int'(low_th) - 1)));
      endcase
      pipe_empty = 2'($urandom);
      recov_busy = ($urandom % 4) == 0;
      rd_req = 1'($urandom);
      if ($urandom % 64 == 0) begin
        low_th = OCC_W'(1 + ($urandom % 200));
        high_th = OCC_W'(int'(low_th) + 2 + ($urandom % 300));
      end
      step();
    end
    chk("R10 saturated", int'(switch_count), CMAX);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule